// File: doc/BRIEF.md
# Privileged Trap and Interrupt Controller

This block holds the privileged control state of a small 64-bit core: a status word, an exception vector, the saved exception PC, a cause code, a captured faulting address, a per-instruction counter with a compare value, and a vector of pending interrupt lines. Every cycle in which the pipeline presents an instruction for retirement, the block decides one of three outcomes. The instruction commits and the next PC is the current PC plus 4. Or a trap is entered: the PC goes to the vector, the state is saved, and supervisor mode is forced. Or, if the trap cannot legally be taken, the core enters a sticky error mode and stops retiring.

Interrupts come from an external set vector and from the internal counter. The counter fires its own line when its value before the increment matches the compare register. A synchronous exception reported by the pipeline for the same instruction outranks any pending interrupt. Software reaches the control registers through a single write port. Writes to the status word are cleaned so that the fields the configuration does not support cannot be set.

Top module: `ptrap_ctrl`

## Requirements
- R1: After reset the status word is supervisor mode (bit 5) plus the supervisor 64-bit bit (bit 7) when 64-bit support is enabled. That gives 0xA0 by default and 0x20 without 64-bit support. Cause, saved PC, captured address, count, pending and error mode are all 0.
- R2: An interrupt trap is taken only when trap-enable (status bit 0) is 1 and the pending vector ANDed with the mask field (status bits 23:16, bit n masking line n) is nonzero. Otherwise the instruction commits.
- R3: When several enabled lines are pending, the lowest-numbered line wins, and the cause becomes 16 plus its index.
- R4: On trap entry trap-enable is cleared and supervisor (bit 5) is set. Previous-supervisor (bit 4) takes the old supervisor bit, so it is 0 when the trap comes from user mode.
- R5: On trap entry the saved PC takes pc_i, the captured address takes badaddr_i and the cause takes the trap number. next_pc_o equals the vector register in that cycle, and no commit is signalled.
- R6: A status write keeps only bits 0, 1, 4, 5, 6, 7 and 23:16. It clears bits 6 and 7 (user and supervisor 64-bit) when 64-bit support is off, and bit 1 (FP enable) when FP support is off.
- R7: xlen64_o is 1 when the 64-bit bit of the current mode is set: bit 7 when supervisor bit 5 is 1, bit 6 otherwise.
- R8: The count rises by one per committed instruction. When its value before the increment equals compare, pending line 7 is set.
- R9: A committing instruction drives commit_o high and next_pc_o to pc_i + 4. A trap or a commit never occurs together with the other.
- R10: A pipeline exception outranks pending interrupts in the same cycle, and its cause code is the one recorded.
- R11: A trap requested while trap-enable is 0, or an exception cause of 32 or more, sets error mode instead of trapping. Error mode is sticky until reset. In error mode nothing commits, no trap is taken, next_pc_o holds pc_i, and register writes are ignored.
- R12: A register write in the same cycle as a trap entry is dropped.
- R13: irq_set_i ORs lines into pending. A write with select 7 clears the pending lines whose data bits are 1. Select codes: 0 status, 1 vector, 2 saved PC, 3 address, 4 cause, 5 count, 6 compare, 7 pending clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | An instruction is presented for retirement |
| pc_i | input | XLEN | PC of that instruction |
| exc_valid_i | input | 1 | Pipeline reports a synchronous exception |
| exc_cause_i | input | CAUSE_W | Exception number |
| badaddr_i | input | XLEN | Faulting address from the memory unit |
| irq_set_i | input | IRQ_N | External interrupt lines to set pending |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 3 | Register select (see R13) |
| csr_wdata_i | input | XLEN | Write data |
| commit_o | output | 1 | Instruction commits this cycle |
| trap_o | output | 1 | Trap entered this cycle |
| next_pc_o | output | XLEN | Next fetch address |
| status_o | output | STAT_W | Status word |
| epc_o | output | XLEN | Saved exception PC |
| cause_o | output | CAUSE_W | Trap cause |
| badaddr_o | output | XLEN | Captured faulting address |
| count_o | output | XLEN | Instruction counter |
| pending_o | output | IRQ_N | Pending interrupt lines |
| xlen64_o | output | 1 | Effective register width is 64 |
| error_mode_o | output | 1 | Fatal error mode |

## Verification
Two cases can fall in one cycle, and each is driven on purpose. In the first, a register write lands together with a trap entry: the write targets the saved PC while an exception retires, and passes only if the saved PC shows the trapping PC. In the second, a pipeline exception arrives while two enabled interrupt lines are pending, and passes only if the recorded cause is the exception number rather than 16 plus the lower line. The lowest-line rule itself is judged separately, with lines 3 and 5 pending together.

// File: rtl/ptrap_pkg.sv
package ptrap_pkg;

    // status bit positions
    localparam int ST_ET     = 0;
    localparam int ST_EF     = 1;
    localparam int ST_PS     = 4;
    localparam int ST_S      = 5;
    localparam int ST_UX     = 6;
    localparam int ST_SX     = 7;
    localparam int ST_IM_LSB = 16;

    // register write selects
    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_EVEC    = 3'd1,
        SEL_EPC     = 3'd2,
        SEL_BADADDR = 3'd3,
        SEL_CAUSE   = 3'd4,
        SEL_COUNT   = 3'd5,
        SEL_COMPARE = 3'd6,
        SEL_PCLR    = 3'd7
    } csr_sel_e;

endpackage

// File: rtl/ptrap_irq_pick.sv
module ptrap_irq_pick #(
    parameter int IRQ_N    = 8,
    parameter int CAUSE_W  = 6,
    parameter int IRQ_BASE = 16
) (
    input  logic [IRQ_N-1:0]   pending_i,
    input  logic [IRQ_N-1:0]   mask_i,
    output logic               any_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [IRQ_N-1:0] live;

    always_comb begin
        live    = pending_i & mask_i;
        any_o   = |live;
        cause_o = '0;
        // scan from the top so the lowest index is the last to write
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (live[i]) begin
                cause_o = CAUSE_W'(IRQ_BASE + i);
            end
        end
    end
endmodule

// File: rtl/ptrap_status_clean.sv
module ptrap_status_clean #(
    parameter int STAT_W = 32,
    parameter int IRQ_N  = 8,
    parameter bit EN64   = 1'b1,
    parameter bit ENFP   = 1'b0
) (
    input  logic [STAT_W-1:0] raw_i,
    output logic [STAT_W-1:0] clean_o
);
    import ptrap_pkg::*;

    localparam logic [STAT_W-1:0] BIT_ET = STAT_W'(1) << ST_ET;
    localparam logic [STAT_W-1:0] BIT_EF = STAT_W'(1) << ST_EF;
    localparam logic [STAT_W-1:0] BIT_PS = STAT_W'(1) << ST_PS;
    localparam logic [STAT_W-1:0] BIT_S  = STAT_W'(1) << ST_S;
    localparam logic [STAT_W-1:0] BIT_UX = STAT_W'(1) << ST_UX;
    localparam logic [STAT_W-1:0] BIT_SX = STAT_W'(1) << ST_SX;
    localparam logic [STAT_W-1:0] IM_FLD = STAT_W'({IRQ_N{1'b1}}) << ST_IM_LSB;
    localparam logic [STAT_W-1:0] KEEP   = BIT_ET | BIT_EF | BIT_PS | BIT_S
                                         | BIT_UX | BIT_SX | IM_FLD;

    logic [STAT_W-1:0] drop64;
    logic [STAT_W-1:0] dropfp;

    generate
        if (EN64) begin : g_w64
            assign drop64 = '0;
        end else begin : g_w32
            assign drop64 = BIT_UX | BIT_SX;
        end
        if (ENFP) begin : g_fp
            assign dropfp = '0;
        end else begin : g_nofp
            assign dropfp = BIT_EF;
        end
    endgenerate

    assign clean_o = raw_i & KEEP & ~drop64 & ~dropfp;
endmodule

// File: rtl/ptrap_timer.sv
module ptrap_timer #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] count_i,
    input  logic [XLEN-1:0] compare_i,
    output logic [XLEN-1:0] count_inc_o,
    output logic            match_o
);
    assign count_inc_o = count_i + XLEN'(1);
    assign match_o     = (count_i == compare_i);
endmodule

// File: rtl/ptrap_ctrl.sv
module ptrap_ctrl #(
    parameter int XLEN       = 64,
    parameter int STAT_W     = 32,
    parameter int IRQ_N      = 8,
    parameter int CAUSE_W    = 6,
    parameter int NUM_TRAPS  = 32,
    parameter int IRQ_BASE   = 16,
    parameter int TIMER_IRQ  = 7,
    parameter bit SUPPORT_64 = 1'b1,
    parameter bit SUPPORT_FP = 1'b0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               retire_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               exc_valid_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic [XLEN-1:0]    badaddr_i,
    input  logic [IRQ_N-1:0]   irq_set_i,
    input  logic               csr_we_i,
    input  logic [2:0]         csr_sel_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic               commit_o,
    output logic               trap_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic [STAT_W-1:0]  status_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [XLEN-1:0]    badaddr_o,
    output logic [XLEN-1:0]    count_o,
    output logic [IRQ_N-1:0]   pending_o,
    output logic               xlen64_o,
    output logic               error_mode_o
);
    import ptrap_pkg::*;

    localparam logic [CAUSE_W-1:0] TRAP_LIM  = CAUSE_W'(NUM_TRAPS);
    localparam logic [IRQ_N-1:0]   TIMER_BIT = IRQ_N'(1) << TIMER_IRQ;
    localparam logic [STAT_W-1:0]  RST_STAT  = (STAT_W'(1) << ST_S)
                                             | (SUPPORT_64 ? (STAT_W'(1) << ST_SX) : '0);

    typedef struct packed {
        logic [STAT_W-1:0]  status;
        logic [XLEN-1:0]    evec;
        logic [XLEN-1:0]    epc;
        logic [XLEN-1:0]    badaddr;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    count;
        logic [XLEN-1:0]    compare;
        logic [IRQ_N-1:0]   pending;
        logic               err;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    // interrupt arbitration
    logic               irq_any;
    logic [CAUSE_W-1:0] irq_cause;

    ptrap_irq_pick #(
        .IRQ_N   (IRQ_N),
        .CAUSE_W (CAUSE_W),
        .IRQ_BASE(IRQ_BASE)
    ) u_pick (
        .pending_i(st_q.pending),
        .mask_i   (st_q.status[ST_IM_LSB +: IRQ_N]),
        .any_o    (irq_any),
        .cause_o  (irq_cause)
    );

    // status cleaning: one path for software writes, one for trap entry
    logic [STAT_W-1:0] wr_stat_clean;
    logic [STAT_W-1:0] trap_stat_raw;
    logic [STAT_W-1:0] trap_stat_clean;

    ptrap_status_clean #(
        .STAT_W(STAT_W), .IRQ_N(IRQ_N), .EN64(SUPPORT_64), .ENFP(SUPPORT_FP)
    ) u_clean_wr (
        .raw_i  (csr_wdata_i[STAT_W-1:0]),
        .clean_o(wr_stat_clean)
    );

    ptrap_status_clean #(
        .STAT_W(STAT_W), .IRQ_N(IRQ_N), .EN64(SUPPORT_64), .ENFP(SUPPORT_FP)
    ) u_clean_trap (
        .raw_i  (trap_stat_raw),
        .clean_o(trap_stat_clean)
    );

    // instruction counter
    logic [XLEN-1:0] count_inc;
    logic            count_match;

    ptrap_timer #(.XLEN(XLEN)) u_timer (
        .count_i    (st_q.count),
        .compare_i  (st_q.compare),
        .count_inc_o(count_inc),
        .match_o    (count_match)
    );

    // decision signals
    logic               live;
    logic               irq_req;
    logic               trap_req;
    logic               bad_cause;
    logic               fatal;
    logic               take;
    logic               commit;
    logic [CAUSE_W-1:0] trap_num;

    always_comb begin
        live      = retire_i && !st_q.err;
        irq_req   = st_q.status[ST_ET] && irq_any;
        trap_req  = exc_valid_i || irq_req;
        bad_cause = exc_valid_i && (exc_cause_i >= TRAP_LIM);
        trap_num  = exc_valid_i ? exc_cause_i : irq_cause;
        fatal     = live && trap_req && (!st_q.status[ST_ET] || bad_cause);
        take      = live && trap_req && !fatal;
        commit    = live && !trap_req;

        trap_stat_raw           = st_q.status;
        trap_stat_raw[ST_ET]    = 1'b0;
        trap_stat_raw[ST_PS]    = st_q.status[ST_S];
        trap_stat_raw[ST_S]     = 1'b1;
    end

    always_comb begin
        st_d = st_q;

        st_d.pending = st_q.pending | irq_set_i;

        if (commit) begin
            st_d.count = count_inc;
            if (count_match) begin
                st_d.pending = st_d.pending | TIMER_BIT;
            end
        end

        if (fatal) begin
            st_d.err = 1'b1;
        end

        if (take) begin
            st_d.status  = trap_stat_clean;
            st_d.cause   = trap_num;
            st_d.epc     = pc_i;
            st_d.badaddr = badaddr_i;
        end else if (csr_we_i && !st_q.err && !fatal) begin
            unique case (csr_sel_e'(csr_sel_i))
                SEL_STATUS:  st_d.status  = wr_stat_clean;
                SEL_EVEC:    st_d.evec    = csr_wdata_i;
                SEL_EPC:     st_d.epc     = csr_wdata_i;
                SEL_BADADDR: st_d.badaddr = csr_wdata_i;
                SEL_CAUSE:   st_d.cause   = csr_wdata_i[CAUSE_W-1:0];
                SEL_COUNT:   st_d.count   = csr_wdata_i;
                SEL_COMPARE: st_d.compare = csr_wdata_i;
                SEL_PCLR:    st_d.pending = st_d.pending & ~csr_wdata_i[IRQ_N-1:0];
                default:     st_d.status  = st_q.status;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.status  <= RST_STAT;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        commit_o     = commit;
        trap_o       = take;
        if (take) begin
            next_pc_o = st_q.evec;
        end else if (st_q.err || fatal) begin
            next_pc_o = pc_i;
        end else begin
            next_pc_o = pc_i + XLEN'(4);
        end
        status_o     = st_q.status;
        epc_o        = st_q.epc;
        cause_o      = st_q.cause;
        badaddr_o    = st_q.badaddr;
        count_o      = st_q.count;
        pending_o    = st_q.pending;
        xlen64_o     = st_q.status[ST_S] ? st_q.status[ST_SX] : st_q.status[ST_UX];
        error_mode_o = st_q.err;
    end
endmodule

// File: rtl/ptrap_ctrl_chk.sv
module ptrap_ctrl_chk #(
    parameter int XLEN       = 64,
    parameter int STAT_W     = 32,
    parameter int IRQ_N      = 8,
    parameter int CAUSE_W    = 6,
    parameter int IRQ_BASE   = 16,
    parameter bit SUPPORT_FP = 1'b0
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [XLEN-1:0]    pc_i,
    input logic               exc_valid_i,
    input logic [CAUSE_W-1:0] exc_cause_i,
    input logic               csr_we_i,
    input logic [2:0]         csr_sel_i,
    input logic               commit_o,
    input logic               trap_o,
    input logic [STAT_W-1:0]  status_o,
    input logic [XLEN-1:0]    epc_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [XLEN-1:0]    count_o,
    input logic               error_mode_o
);
    import ptrap_pkg::*;

    localparam logic [STAT_W-1:0] LEGAL = (STAT_W'(1) << ST_ET) | (STAT_W'(1) << ST_EF)
                                        | (STAT_W'(1) << ST_PS) | (STAT_W'(1) << ST_S)
                                        | (STAT_W'(1) << ST_UX) | (STAT_W'(1) << ST_SX)
                                        | (STAT_W'({IRQ_N{1'b1}}) << ST_IM_LSB);
    localparam logic [CAUSE_W-1:0] BASE_C = CAUSE_W'(IRQ_BASE);

    p_irq_needs_et_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && !exc_valid_i) |-> status_o[ST_ET]);

    p_irq_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && !exc_valid_i) |=> (cause_o >= BASE_C));

    p_enter_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |=> (!status_o[ST_ET] && status_o[ST_S]));

    p_prev_sup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |=> (status_o[ST_PS] == $past(status_o[ST_S])));

    p_save_pc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |=> (epc_o == $past(pc_i)));

    p_rsvd_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_o & ~LEGAL) == '0) && (SUPPORT_FP || !status_o[ST_EF]));

    p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_o && !(csr_we_i && csr_sel_i == SEL_COUNT))
        |=> (count_o == $past(count_o) + XLEN'(1)));

    p_one_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(commit_o && trap_o));

    p_exc_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && exc_valid_i) |=> (cause_o == $past(exc_cause_i)));

    p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_mode_o |=> error_mode_o);

    p_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_mode_o |-> (!commit_o && !trap_o));

    p_write_dropped_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && csr_we_i && csr_sel_i == SEL_EPC) |=> (epc_o == $past(pc_i)));
endmodule

bind ptrap_ctrl ptrap_ctrl_chk #(
    .XLEN      (XLEN),
    .STAT_W    (STAT_W),
    .IRQ_N     (IRQ_N),
    .CAUSE_W   (CAUSE_W),
    .IRQ_BASE  (IRQ_BASE),
    .SUPPORT_FP(SUPPORT_FP)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_i        (pc_i),
    .exc_valid_i (exc_valid_i),
    .exc_cause_i (exc_cause_i),
    .csr_we_i    (csr_we_i),
    .csr_sel_i   (csr_sel_i),
    .commit_o    (commit_o),
    .trap_o      (trap_o),
    .status_o    (status_o),
    .epc_o       (epc_o),
    .cause_o     (cause_o),
    .count_o     (count_o),
    .error_mode_o(error_mode_o)
);

// File: tb/tb_ptrap_ctrl.sv
module tb_ptrap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        retire;
    logic [63:0] pc;
    logic        exc_v;
    logic [5:0]  exc_c;
    logic [63:0] baddr;
    logic [7:0]  irq_set;
    logic        we;
    logic [2:0]  sel;
    logic [63:0] wdata;

    logic        commit, trap, x64, err;
    logic [63:0] npc, epc, badaddr_q, count;
    logic [31:0] status;
    logic [5:0]  cause;
    logic [7:0]  pend;

    logic        n_commit, n_trap, n_x64, n_err;
    logic [63:0] n_npc, n_epc, n_bad, n_count;
    logic [31:0] n_status;
    logic [5:0]  n_cause;
    logic [7:0]  n_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ptrap_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .pc_i(pc),
        .exc_valid_i(exc_v), .exc_cause_i(exc_c), .badaddr_i(baddr),
        .irq_set_i(irq_set), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
        .commit_o(commit), .trap_o(trap), .next_pc_o(npc), .status_o(status),
        .epc_o(epc), .cause_o(cause), .badaddr_o(badaddr_q), .count_o(count),
        .pending_o(pend), .xlen64_o(x64), .error_mode_o(err)
    );

    ptrap_ctrl #(.SUPPORT_64(1'b0)) dut_n64 (
        .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .pc_i(pc),
        .exc_valid_i(exc_v), .exc_cause_i(exc_c), .badaddr_i(baddr),
        .irq_set_i(irq_set), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
        .commit_o(n_commit), .trap_o(n_trap), .next_pc_o(n_npc), .status_o(n_status),
        .epc_o(n_epc), .cause_o(n_cause), .badaddr_o(n_bad), .count_o(n_count),
        .pending_o(n_pend), .xlen64_o(n_x64), .error_mode_o(n_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        retire = 0; pc = '0; exc_v = 0; exc_c = '0; baddr = '0;
        irq_set = '0; we = 0; sel = '0; wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic csr_write(input logic [2:0] s, input logic [63:0] d);
        we = 1; sel = s; wdata = d;
        @(negedge clk);
        idle();
    endtask

    // drives one retire; returns combinational outcome of that cycle
    task automatic do_retire(input logic [63:0] p, input logic ev, input logic [5:0] ec,
                             input logic [63:0] ba, output logic c, output logic t,
                             output logic [63:0] np);
        retire = 1; pc = p; exc_v = ev; exc_c = ec; baddr = ba;
        #1;
        c = commit; t = trap; np = npc;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        check("R1 status", 64'(status), 64'h0000_00A0);
        check("R1 status no64", 64'(n_status), 64'h0000_0020);
        check("R1 cause", 64'(cause), 64'd0);
        check("R1 epc", epc, 64'd0);
        check("R1 badaddr", badaddr_q, 64'd0);
        check("R1 count", count, 64'd0);
        check("R1 pending", 64'(pend), 64'd0);
        check("R1 error", 64'(err), 64'd0);
        check("R7 width at reset", 64'(x64), 64'd1);
        check("R7 width no64", 64'(n_x64), 64'd0);
    endtask

    task automatic t_sanitize_width();
        csr_write(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R6 status all ones", 64'(status), 64'h00FF_00F1);
        check("R6 status all ones no64", 64'(n_status), 64'h00FF_0031);
        check("R7 sup+sx", 64'(x64), 64'd1);
        csr_write(3'd0, 64'h40);
        check("R7 user+ux", 64'(x64), 64'd1);
        check("R6 ux dropped no64", 64'(n_status), 64'h0);
        csr_write(3'd0, 64'h20);
        check("R7 sup no sx", 64'(x64), 64'd0);
        csr_write(3'd0, 64'h80);
        check("R7 user with only sx", 64'(x64), 64'd0);
    endtask

    task automatic t_commit();
        logic c, t;
        logic [63:0] np;
        csr_write(3'd6, 64'd100);
        do_retire(64'h1000, 0, 0, 0, c, t, np);
        check("R9 commit", 64'(c), 64'd1);
        check("R9 no trap", 64'(t), 64'd0);
        check("R9 next pc", np, 64'h1004);
        check("R8 count one", count, 64'd1);
        do_retire(64'h2FFC, 0, 0, 0, c, t, np);
        check("R9 next pc carry", np, 64'h3000);
        check("R8 count two", count, 64'd2);
        check("R8 no early timer", 64'(pend), 64'd0);
    endtask

    task automatic t_timer();
        logic c, t;
        logic [63:0] np;
        csr_write(3'd6, 64'd5);
        csr_write(3'd5, 64'd5);
        check("R8 no timer without retire", 64'(pend), 64'd0);
        do_retire(64'h3000, 0, 0, 0, c, t, np);
        check("R8 timer line", 64'(pend), 64'h80);
        check("R8 count after match", count, 64'd6);
        do_retire(64'h3004, 0, 0, 0, c, t, np);
        check("R8 count seven", count, 64'd7);
    endtask

    task automatic t_gating();
        logic c, t;
        logic [63:0] np;
        csr_write(3'd1, 64'h8000);
        csr_write(3'd0, 64'h00FF_00A0);
        do_retire(64'h100, 0, 0, 0, c, t, np);
        check("R2 et clear commits", 64'(c), 64'd1);
        check("R2 et clear no trap", 64'(t), 64'd0);
        check("R2 et clear no error", 64'(err), 64'd0);
        csr_write(3'd0, 64'h0000_00A1);
        do_retire(64'h104, 0, 0, 0, c, t, np);
        check("R2 mask zero commits", 64'(c), 64'd1);
        csr_write(3'd0, 64'h00FF_00A1);
        do_retire(64'h4440, 0, 0, 64'h77, c, t, np);
        check("R2 enabled traps", 64'(t), 64'd1);
        check("R5 no commit on trap", 64'(c), 64'd0);
        check("R5 next pc vector", np, 64'h8000);
        check("R3 timer cause", 64'(cause), 64'd23);
        check("R5 epc", epc, 64'h4440);
        check("R5 badaddr", badaddr_q, 64'h77);
        check("R4 status after trap", 64'(status), 64'h00FF_00B0);
        check("R8 no count on trap", count, 64'd9);
    endtask

    task automatic t_priority();
        logic c, t;
        logic [63:0] np;
        csr_write(3'd7, 64'hFF);
        check("R13 clear pending", 64'(pend), 64'h0);
        irq_set = 8'h28;
        @(negedge clk);
        idle();
        check("R13 set pending", 64'(pend), 64'h28);
        csr_write(3'd0, 64'h00FF_0081);
        check("R7 user no ux", 64'(x64), 64'd0);
        do_retire(64'h500, 0, 0, 0, c, t, np);
        check("R3 trap taken", 64'(t), 64'd1);
        check("R3 lowest line wins", 64'(cause), 64'd19);
        check("R4 from user", 64'(status), 64'h00FF_00A0);
    endtask

    task automatic t_exc_first();
        logic c, t;
        logic [63:0] np;
        csr_write(3'd0, 64'h00FF_00A1);
        do_retire(64'h600, 1, 6'd6, 64'hDEAD_BEEF, c, t, np);
        check("R10 trap", 64'(t), 64'd1);
        check("R10 exception cause", 64'(cause), 64'd6);
        check("R5 exc badaddr", badaddr_q, 64'hDEAD_BEEF);
        check("R5 exc epc", epc, 64'h600);
        check("R4 from sup", 64'(status), 64'h00FF_00B0);
    endtask

    task automatic t_write_drop();
        logic c, t;
        logic [63:0] np;
        csr_write(3'd0, 64'h00FF_00A1);
        we = 1; sel = 3'd2; wdata = 64'h1234;
        do_retire(64'h700, 1, 6'd2, 0, c, t, np);
        check("R12 trap with write", 64'(t), 64'd1);
        check("R12 epc keeps trap pc", epc, 64'h700);
        check("R12 cause", 64'(cause), 64'd2);
    endtask

    task automatic t_fatal();
        logic c, t;
        logic [63:0] np;
        logic [63:0] cnt0;
        cnt0 = count;
        do_retire(64'h900, 1, 6'd3, 0, c, t, np);
        check("R11 no trap when et clear", 64'(t), 64'd0);
        check("R11 no commit", 64'(c), 64'd0);
        check("R11 pc held", np, 64'h900);
        check("R11 error set", 64'(err), 64'd1);
        check("R11 cause kept", 64'(cause), 64'd2);
        do_retire(64'hA00, 0, 0, 0, c, t, np);
        check("R11 halted", 64'(c), 64'd0);
        check("R11 count frozen", count, cnt0);
        csr_write(3'd0, 64'hA1);
        check("R11 write ignored", 64'(status), 64'h00FF_00B0);
        check("R11 sticky", 64'(err), 64'd1);
        do_reset();
        t_reset();
        csr_write(3'd0, 64'hA1);
        do_retire(64'hB00, 1, 6'd40, 0, c, t, np);
        check("R11 bad cause no trap", 64'(t), 64'd0);
        check("R11 bad cause error", 64'(err), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_sanitize_width();
        t_commit();
        t_timer();
        t_gating();
        t_priority();
        t_exc_first();
        t_write_drop();
        t_fatal();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule